// File: doc/BRIEF.md
# Two-Half Sector Parity Code Engine for NAND Data Path

This block sits beside the byte stream of a NAND data path. While it is accumulating, it computes a Hamming-style single-error-correcting code over each 512-byte sector. The sector is handled as two independent 256-byte halves. For each half the engine keeps sixteen line-parity bits, which encode the byte index, and six column-parity bits, which encode the bit position. That gives three code bytes per half and six per sector. Using these codes to correct data is left to the host.

Software steers the engine by writing one-byte mode codes. One code clears the accumulators. Another makes every valid byte count towards the code. A third turns the data-register read path into a result port. In result mode the six code bytes come back as three 16-bit words, interleaved across the two halves. The host usually issues one dummy data read after a clear and before it enters accumulate mode, and the engine must not react to that read.

Top module: `nand_ecc_dual`

## Requirements
- R1: Writing mode code 0xF4 clears both halves' accumulators and the byte counter at that clock edge, so a later readout returns 0xFFFF for all three words.
- R2: While the mode is 0xB4, each cycle with `byte_vld` high adds `byte_data` to one half. Stream bytes 0 to 255 go to the first half and bytes 256 to 511 go to the second half.
- R3: Line parity for a half: for k = 0..7, LP(2k+1) is the XOR of all data bits in the bytes whose in-half index has bit k set, and LP(2k) is the same XOR over the bytes whose index has bit k clear.
- R4: Column parity for a half: for j = 0..2, CP(2j+1) is the XOR over all bytes of the data bits at positions whose bit-number bit j is 1, and CP(2j) is the same XOR over positions where that bit is 0. The column byte is {CP5..CP0, 1, 1}, with CP5 in bit 7.
- R5: All code bits are reported inverted, so a sector of 512 bytes of 0xFF reads back as three words of 0xFFFF.
- R6: In mode 0xD4, `rd_word` presents word 0 = {LP15..8, LP7..0} of the first half, then word 1 = {LP7..0 of the second half, column byte of the first half}, then word 2 = {column byte of the second half, LP15..8 of the second half}. In each pair the high byte is written first.
- R7: In result mode each `rd_stb` moves on to the next word, and after word 2 the sequence returns to word 0. Any mode write restarts the sequence at word 0.
- R8: Outside result mode, `rd_stb` changes neither the accumulators nor the word sequence, and `rd_word` reads 0.
- R9: Bytes presented while the mode is not 0xB4 leave the accumulators and the byte counter unchanged.
- R10: The byte counter wraps at 512, so byte 512 after a clear goes to index 0 of the first half.
- R11: After reset the accumulators are clear and the mode is idle (0x00). Entering result mode without a clear therefore reads 0xFFFF words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_code | input | 8 | Mode code written with `mode_wr` |
| byte_vld | input | 1 | A data byte passes this cycle |
| byte_data | input | 8 | Data byte |
| rd_stb | input | 1 | Data-register read strobe; the current word is taken this cycle |
| rd_word | output | 16 | Current result word, or 0 outside result mode |

## Verification
The assertions assume that a mode write never arrives in the same cycle as a data byte or a read strobe. They also assume that the strobes are clean, single-cycle pulses sampled at the rising edge. The stimulus keeps to this by driving only one kind of event per cycle, changing inputs on the falling edge. Between directed sequences it mixes random sector contents and random stream lengths, covering the erased page, a single flipped bit in the second half, the dummy read, stray bytes in the wrong mode and counter wrap.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int HALF_BYTES = 256;
  localparam int IDX_W      = $clog2(HALF_BYTES);
  localparam int LP_W       = 2 * IDX_W;
  localparam int BIT_SEL_W  = 3;
  localparam int CP_W       = 2 * BIT_SEL_W;
  localparam int CNT_W      = IDX_W + 1;
  localparam int NUM_HALVES = 2;
  localparam int WORD_W     = 16;
  localparam int NUM_WORDS  = 3;

  localparam logic [7:0] MODE_IDLE = 8'h00;
  localparam logic [7:0] MODE_CLR  = 8'hF4;
  localparam logic [7:0] MODE_ACC  = 8'hB4;
  localparam logic [7:0] MODE_RES  = 8'hD4;

  // Line-parity contribution of one byte at in-half index idx
  function automatic logic [LP_W-1:0] lp_step(input logic [IDX_W-1:0] idx,
                                              input logic [7:0] d);
    logic par;
    logic [LP_W-1:0] r;
    par = ^d;
    for (int k = 0; k < IDX_W; k++) begin
      r[2*k+1] = par & idx[k];
      r[2*k]   = par & ~idx[k];
    end
    return r;
  endfunction

  // Column-parity contribution of one byte
  function automatic logic [CP_W-1:0] cp_step(input logic [7:0] d);
    logic [CP_W-1:0] r;
    r = '0;
    for (int j = 0; j < BIT_SEL_W; j++) begin
      for (int b = 0; b < 8; b++) begin
        if (((b >> j) & 1) == 1) r[2*j+1] = r[2*j+1] ^ d[b];
        else                     r[2*j]   = r[2*j]   ^ d[b];
      end
    end
    return r;
  endfunction

  // Reported column byte: inverted column parity, two low bits fixed high
  function automatic logic [7:0] col_byte(input logic [CP_W-1:0] cp_raw);
    return {~cp_raw, 2'b11};
  endfunction
endpackage

// File: rtl/ecc_seq_ctrl.sv
module ecc_seq_ctrl
  import nand_ecc_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_wr,
  input  logic [7:0]    mode_code,
  input  logic          byte_vld,
  output logic          clr_pulse,
  output logic          acc_fire,
  output logic          res_mode,
  output logic [CW-1:0] byte_pos
);
  logic [7:0]    mode_q;
  logic [CW-1:0] cnt_q;

  assign clr_pulse = mode_wr && (mode_code == MODE_CLR);
  assign acc_fire  = byte_vld && (mode_q == MODE_ACC) && !clr_pulse;
  assign res_mode  = (mode_q == MODE_RES);
  assign byte_pos  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_IDLE;
    end else if (mode_wr) begin
      mode_q <= mode_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_pulse) begin
      cnt_q <= '0;
    end else if (acc_fire) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (cnt_q == '0)); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> (cnt_q == $past(cnt_q) + 1'b1)); // R10
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_fire && !clr_pulse) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/ecc_half_acc.sv
module ecc_half_acc
  import nand_ecc_pkg::*;
#(
  parameter int          CW      = CNT_W,
  parameter int          IW      = IDX_W,
  parameter logic        HALF_ID = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            fire,
  input  logic [CW-1:0]   pos,
  input  logic [7:0]      data,
  output logic            upd,
  output logic [LP_W-1:0] lp_raw,
  output logic [CP_W-1:0] cp_raw
);
  logic [LP_W-1:0] lp_q;
  logic [CP_W-1:0] cp_q;

  assign upd    = fire && (pos[CW-1] == HALF_ID);
  assign lp_raw = lp_q;
  assign cp_raw = cp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_q <= '0;
      cp_q <= '0;
    end else if (clr) begin
      lp_q <= '0;
      cp_q <= '0;
    end else if (upd) begin
      lp_q <= lp_q ^ lp_step(pos[IW-1:0], data);
      cp_q <= cp_q ^ cp_step(data);
    end
  end

  AST_HALF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (lp_q == '0 && cp_q == '0)); // R1
  AST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !clr) |=> ($stable(lp_q) && $stable(cp_q))); // R9
  AST_HALF_CPAR: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> ((^(lp_q ^ $past(lp_q))) == 1'b0)); // R3
endmodule

// File: rtl/ecc_readout.sv
module ecc_readout
  import nand_ecc_pkg::*;
#(
  parameter int WW = WORD_W,
  parameter int NW = NUM_WORDS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_wr,
  input  logic            res_mode,
  input  logic            rd_stb,
  input  logic [LP_W-1:0] lp_a,
  input  logic [CP_W-1:0] cp_a,
  input  logic [LP_W-1:0] lp_b,
  input  logic [CP_W-1:0] cp_b,
  output logic [WW-1:0]   rd_word
);
  localparam int SEL_W = $clog2(NW);

  logic [SEL_W-1:0] sel_q;
  logic             step;
  logic [LP_W-1:0]  lpn_a, lpn_b;
  logic [7:0]       col_a, col_b;
  logic [WW-1:0]    word_mux;

  assign step  = rd_stb && res_mode && !mode_wr;
  assign lpn_a = ~lp_a;
  assign lpn_b = ~lp_b;
  assign col_a = col_byte(cp_a);
  assign col_b = col_byte(cp_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (mode_wr) begin
      sel_q <= '0;
    end else if (step) begin
      sel_q <= (sel_q == SEL_W'(NW - 1)) ? '0 : sel_q + 1'b1;
    end
  end

  always_comb begin
    case (sel_q)
      2'd0:    word_mux = {lpn_a[15:8], lpn_a[7:0]};
      2'd1:    word_mux = {lpn_b[7:0], col_a};
      default: word_mux = {col_b, lpn_b[15:8]};
    endcase
  end

  assign rd_word = res_mode ? word_mux : '0;

  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q <= SEL_W'(NW - 1)); // R7
  AST_SEL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (sel_q == '0)); // R7
  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_mode && !mode_wr) |=> $stable(sel_q)); // R8
endmodule

// File: rtl/nand_ecc_dual.sv
module nand_ecc_dual
  import nand_ecc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_wr,
  input  logic [7:0]  mode_code,
  input  logic        byte_vld,
  input  logic [7:0]  byte_data,
  input  logic        rd_stb,
  output logic [15:0] rd_word
);
  logic             clr_pulse, acc_fire, res_mode;
  logic [CNT_W-1:0] byte_pos;
  logic [NUM_HALVES-1:0] half_upd;
  logic [LP_W-1:0]  lp_raw [NUM_HALVES];
  logic [CP_W-1:0]  cp_raw [NUM_HALVES];

  ecc_seq_ctrl #(.CW(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_code(mode_code),
    .byte_vld(byte_vld), .clr_pulse(clr_pulse), .acc_fire(acc_fire),
    .res_mode(res_mode), .byte_pos(byte_pos)
  );

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    ecc_half_acc #(.CW(CNT_W), .IW(IDX_W), .HALF_ID(1'(h))) u_half (
      .clk(clk), .rst_n(rst_n), .clr(clr_pulse), .fire(acc_fire),
      .pos(byte_pos), .data(byte_data), .upd(half_upd[h]),
      .lp_raw(lp_raw[h]), .cp_raw(cp_raw[h])
    );
  end

  ecc_readout #(.WW(WORD_W), .NW(NUM_WORDS)) u_rd (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .res_mode(res_mode),
    .rd_stb(rd_stb), .lp_a(lp_raw[0]), .cp_a(cp_raw[0]),
    .lp_b(lp_raw[1]), .cp_b(cp_raw[1]), .rd_word(rd_word)
  );

  AST_ONE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(half_upd)); // R2
  AST_FIRE_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |-> ($countones(half_upd) == 1)); // R2
  AST_QUIET_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_code != MODE_RES) |=> (rd_word == '0)); // R8
endmodule

// File: tb/nand_ecc_dual_tb.sv
module nand_ecc_dual_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 1'b0;
  logic [7:0]  mode_code = 8'h00;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_data = 8'h00;
  logic        rd_stb = 1'b0;
  logic [15:0] rd_word;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [15:0] m_lp [2];
  logic [5:0]  m_cp [2];
  int          m_cnt;
  logic [7:0]  m_mode;

  always #5 clk = ~clk;

  nand_ecc_dual dut_i (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_code(mode_code),
    .byte_vld(byte_vld), .byte_data(byte_data), .rd_stb(rd_stb),
    .rd_word(rd_word)
  );

  task automatic chk(input string tag, input logic [15:0] got,
                     input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input int n);
    logic [15:0] a, b;
    logic [7:0]  ca, cb;
    a  = ~m_lp[0];
    b  = ~m_lp[1];
    ca = {~m_cp[0], 2'b11};
    cb = {~m_cp[1], 2'b11};
    case (n)
      0:       return {a[15:8], a[7:0]};
      1:       return {b[7:0], ca};
      default: return {cb, b[15:8]};
    endcase
  endfunction

  task automatic set_mode(input logic [7:0] code);
    @(negedge clk);
    mode_wr = 1'b1; mode_code = code;
    @(negedge clk);
    mode_wr = 1'b0;
    m_mode = code;
    if (code == 8'hF4) begin
      m_lp[0] = '0; m_lp[1] = '0; m_cp[0] = '0; m_cp[1] = '0; m_cnt = 0;
    end
  endtask

  task automatic send_byte(input logic [7:0] d);
    @(negedge clk);
    byte_vld = 1'b1; byte_data = d;
    @(negedge clk);
    byte_vld = 1'b0;
    if (m_mode == 8'hB4) begin
      int h, i;
      h = m_cnt / 256;
      i = m_cnt % 256;
      for (int b = 0; b < 8; b++) begin
        if (d[b]) begin
          for (int k = 0; k < 8; k++) m_lp[h][2*k + ((i >> k) & 1)] ^= 1'b1;
          for (int j = 0; j < 3; j++) m_cp[h][2*j + ((b >> j) & 1)] ^= 1'b1;
        end
      end
      m_cnt = (m_cnt + 1) % 512;
    end
  endtask

  task automatic read_one(output logic [15:0] w);
    @(negedge clk);
    w = rd_word;
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic read_all(input string tag);
    logic [15:0] w;
    for (int n = 0; n < 3; n++) begin
      read_one(w);
      chk($sformatf("%s word%0d", tag, n), w, exp_word(n));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired got=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    void'($urandom(32'h5eed_1234));
    m_lp[0] = '0; m_lp[1] = '0; m_cp[0] = '0; m_cp[1] = '0;
    m_cnt = 0; m_mode = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: idle mode output quiet; R11 reset state
    @(negedge clk);
    chk("R8 idle rd_word", rd_word, 16'h0000);
    set_mode(8'hD4);
    read_all("R11 reset state");

    // R5 erased page with dummy read after clear (R8)
    set_mode(8'hF4);
    read_one(w);
    chk("R8 dummy read output", w, 16'h0000);
    set_mode(8'hB4);
    for (int i = 0; i < 512; i++) send_byte(8'hFF);
    set_mode(8'hD4);
    read_all("R5 erased page");

    // R2 R3 R4 R6 single flipped bit in second half: byte 300 bit 5
    set_mode(8'hF4);
    set_mode(8'hB4);
    for (int i = 0; i < 512; i++) send_byte(i == 300 ? 8'h20 : 8'h00);
    set_mode(8'hD4);
    read_all("R2 R3 R4 single bit half1");

    // R7 wrap to word 0 then restart on mode write
    read_one(w);
    chk("R7 fourth read wraps", w, exp_word(0));
    read_one(w);
    chk("R7 fifth read", w, exp_word(1));
    set_mode(8'hD4);
    read_one(w);
    chk("R7 restart on mode write", w, exp_word(0));

    // R9 bytes in result mode ignored
    for (int i = 0; i < 5; i++) send_byte(8'($urandom));
    set_mode(8'hD4);
    read_all("R9 bytes outside accumulate");

    // random sectors, R3 R4 R6 R2
    for (int r = 0; r < 4; r++) begin
      set_mode(8'hF4);
      read_one(w);
      set_mode(8'hB4);
      for (int i = 0; i < 512; i++) send_byte(8'($urandom));
      read_one(w);
      chk("R8 read in accumulate", w, 16'h0000);
      set_mode(8'hD4);
      read_all($sformatf("R6 R3 R4 random sector %0d", r));
    end

    // R10 wrap at 512: continue past the sector without clear
    set_mode(8'hF4);
    set_mode(8'hB4);
    for (int i = 0; i < 512; i++) send_byte(8'($urandom));
    for (int i = 0; i < 9; i++) send_byte(8'($urandom));
    set_mode(8'hD4);
    read_all("R10 counter wrap");

    // R1 clear after data gives all ones
    set_mode(8'hF4);
    set_mode(8'hD4);
    read_all("R1 clear");

    // R9 bytes in clear mode ignored, short random stream
    set_mode(8'hF4);
    send_byte(8'hA5);
    set_mode(8'hB4);
    for (int i = 0; i < 37; i++) send_byte(8'($urandom));
    set_mode(8'hD4);
    read_all("R9 R2 short stream");

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule